// File: doc/BRIEF.md
# Serial ADC Sampling Controller

This block is the master side of a three-wire link to a 10-bit single-channel successive-approximation converter. It divides the system clock down to a serial clock. It opens every frame by pulling chip select low, which also starts the next conversion in the converter. It then runs sixteen serial-clock pulses and captures one data bit on each rising edge. When chip select returns high, the block presents the 10-bit result with a one-cycle valid strobe.

Between frames chip select stays high and the serial clock stays stopped. This gap gives the converter its quiet time and its track time. A run-time period input sets the frame spacing, counted in serial-clock periods, and so sets the sample rate. Values below the legal minimum are raised to that minimum.

Dropping the enable input, or raising the power-down input, lets the current frame finish and then keeps the converter shut down. A later restart first waits about one microsecond with chip select high, so the converter has time to wake.

Top module: `adc_sampler`

## Requirements
- R1: While reset is asserted and in the first cycle after release, chip select is high, the serial clock is low, valid is low and the sample output is zero.
- R2: A frame starts when chip select falls, with the serial clock low at that point. Chip select then stays low for exactly (2*FRAME_BITS+1)*SCLK_HALF system cycles: 231 cycles with the defaults.
- R3: Each frame carries exactly FRAME_BITS serial-clock pulses (16 by default). Each high phase and each low phase lasts SCLK_HALF system cycles. The serial clock is high only while chip select is low.
- R4: The data line is sampled in the cycle in which the serial clock rises, and the first bit received is the most significant. The sample output holds received bits FRAME_BITS-1-LEAD_BITS down to FRAME_BITS-LEAD_BITS-RES, which is bits 12 to 3 of the 16-bit received word with the defaults. It is unsigned natural binary, and the filler bits on either side are discarded.
- R5: The valid output pulses high for exactly one cycle, in the cycle in which chip select returns high. The sample output does not change between pulses.
- R6: While the block keeps running, successive chip-select falls are 2*max(period_i, MIN_PERIOD)*SCLK_HALF system cycles apart. The period input is sampled when a frame starts.
- R7: A frame in progress always runs to completion. If enable is low or power-down is high when the frame ends, chip select stays high and the serial clock stays low until running is requested again.
- R8: From idle, chip select falls on the WAKE_CYC-th consecutive clock edge at which enable is high and power-down is low. WAKE_CYC is 125 at 125 MHz. Any break in that run of edges restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run request for periodic sampling |
| pd_i | input | 1 | Power-down request; takes priority over en_i |
| period_i | input | PER_W | Frame spacing in serial-clock periods; values below MIN_PERIOD are raised to MIN_PERIOD |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| sample_o | output | RES | Most recent conversion result |
| valid_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
The assertions assume that reset is the only thing that breaks the frame timing. They also assume that the control inputs change only between clock edges. The checks that count serial-clock phases and pulses per frame assume that the divider parameter keeps the serial clock inside its legal band. They rely on the serial clock being derived purely by counting system cycles. The stimulus changes en_i, pd_i and period_i only on falling clock edges. It raises power-down in the middle of a frame, drops enable before the wake count has finished, and sets periods both below and above the minimum. The converter model moves its data line only a short delay after a serial-clock fall or a chip-select fall, so the data is stable at every capture edge.

// File: rtl/adc_sampler.sv
module adc_sampler #(
  parameter int CLK_KHZ    = 125000,
  parameter int SCLK_HALF  = 7,
  parameter int RES        = 10,
  parameter int FRAME_BITS = 16,
  parameter int LEAD_BITS  = 3,
  parameter int MIN_PERIOD = 20,
  parameter int PER_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             pd_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             sdata_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic [RES-1:0]   sample_o,
  output logic             valid_o
);
  localparam int SCLK_KHZ = CLK_KHZ / (2 * SCLK_HALF);
  localparam int WAKE_CYC = (CLK_KHZ + 999) / 1000;
  localparam int UNIT_W   = PER_W + 1;
  localparam int DIV_W    = $clog2(SCLK_HALF + 1);
  localparam int WAKE_W   = $clog2(WAKE_CYC + 1);
  localparam int LOW_END  = 2 * FRAME_BITS;
  localparam int TOP_BIT  = FRAME_BITS - 1 - LEAD_BITS;

  if (SCLK_KHZ < 4000 || SCLK_KHZ > 10000) begin : g_bad_div
    $error("SCLK_HALF gives a serial clock outside 4..10 MHz");
  end
  if (2 * MIN_PERIOD <= LOW_END + 1 || TOP_BIT + 1 < RES) begin : g_bad_frame
    $error("frame parameters inconsistent");
  end

  logic                  run_q, run_n;
  logic [UNIT_W-1:0]     unit_q, unit_n;
  logic [DIV_W-1:0]      div_q;
  logic [PER_W-1:0]      per_q;
  logic [WAKE_W-1:0]     wake_q;
  logic [FRAME_BITS-1:0] shift_q;

  wire             go        = en_i & ~pd_i;
  wire [PER_W-1:0] per_eff   = (period_i < PER_W'(MIN_PERIOD)) ? PER_W'(MIN_PERIOD) : period_i;
  wire             tick      = run_q && (div_q == DIV_W'(SCLK_HALF - 1));
  wire             last_unit = unit_q == ({per_q, 1'b0} - UNIT_W'(1));
  wire             start     = ~run_q & go & (wake_q == WAKE_W'(WAKE_CYC - 1));
  wire             reload    = tick & last_unit & go;

  always_comb begin
    run_n  = run_q;
    unit_n = unit_q;
    if (start) begin
      run_n  = 1'b1;
      unit_n = '0;
    end else if (tick) begin
      if (last_unit) begin
        if (go) unit_n = '0;
        else    run_n  = 1'b0;
      end else begin
        unit_n = unit_q + UNIT_W'(1);
      end
    end
  end

  wire cs_low_n = run_n && (unit_n <= UNIT_W'(LOW_END));
  wire sclk_n   = run_n && unit_n[0] && (unit_n < UNIT_W'(LOW_END));
  wire capture  = sclk_n & ~sclk_o;
  wire finish   = ~cs_low_n & ~cs_n_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      unit_q   <= '0;
      div_q    <= '0;
      per_q    <= PER_W'(MIN_PERIOD);
      wake_q   <= '0;
      shift_q  <= '0;
      cs_n_o   <= 1'b1;
      sclk_o   <= 1'b0;
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      run_q  <= run_n;
      unit_q <= unit_n;
      div_q  <= (!run_n || start || tick) ? '0 : div_q + DIV_W'(1);
      if (start || reload) per_q <= per_eff;
      if (run_q || start || !go) wake_q <= '0;
      else                       wake_q <= wake_q + WAKE_W'(1);
      if (capture) shift_q <= {shift_q[FRAME_BITS-2:0], sdata_i};
      cs_n_o  <= ~cs_low_n;
      sclk_o  <= sclk_n;
      valid_o <= finish;
      if (finish) sample_o <= shift_q[TOP_BIT -: RES];
    end
  end
endmodule

module adc_sampler_chk #(
  parameter int SCLK_HALF  = 7,
  parameter int FRAME_BITS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic pd_i,
  input logic cs_n_o,
  input logic sclk_o,
  input logic valid_o
);
  logic [15:0] hcnt;
  logic [15:0] rcnt;
  logic        sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt   <= '0;
      rcnt   <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_o;
      hcnt   <= sclk_o ? hcnt + 16'd1 : 16'd0;
      if (cs_n_o)                rcnt <= '0;
      else if (sclk_o && !sclk_d) rcnt <= rcnt + 16'd1;
    end
  end

  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) sclk_o |-> !cs_n_o); // R3
  AST_SCLK_PHASE: assert property (@(posedge clk) disable iff (!rst_n) $fell(sclk_o) |-> (hcnt == 16'(SCLK_HALF))); // R3
  AST_BITS_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n_o) |-> (rcnt == 16'(FRAME_BITS))); // R3
  AST_CS_LEADS_SCLK: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n_o) |-> !sclk_o); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) valid_o |=> !valid_o); // R5
  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n) valid_o |-> $rose(cs_n_o)); // R5
  AST_PD_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (pd_i && cs_n_o) |=> cs_n_o); // R7
endmodule

bind adc_sampler adc_sampler_chk #(.SCLK_HALF(SCLK_HALF), .FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_i(pd_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .valid_o(valid_o)
);

// File: tb/adc_sampler_tb.sv
module adc_sampler_tb_top;
  localparam int HALF = 7;
  localparam int WAKE = 125;
  localparam int MINP = 20;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       en = 0, pd = 0, sdata = 0;
  logic [7:0] period = 8'd25;
  logic       cs_n, sclk, valid;
  logic [9:0] sample;

  adc_sampler dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .pd_i(pd), .period_i(period),
    .sdata_i(sdata), .cs_n_o(cs_n), .sclk_o(sclk), .sample_o(sample), .valid_o(valid)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // converter model
  logic [15:0] words [8] = '{16'hE005, 16'h1FFA, 16'hF557, 16'h0AA8,
                             16'hA003, 16'h4FFC, 16'h8000, 16'h7FFF};
  logic [15:0] cur;
  int          bitp, fidx = 0;
  int          exp_q[$];

  always @(negedge cs_n) begin
    cur = words[fidx % 8];
    fidx++;
    exp_q.push_back(int'(cur[12:3]));
    bitp = 15;
    #1 sdata = cur[15];
  end
  always @(negedge sclk) if (!cs_n) begin
    bitp--;
    #1 if (bitp >= 0) sdata = cur[bitp];
  end

  // reference model
  bit mrun = 0;
  int mt = 0, mlen = 0, mwake = 0;
  function automatic int eff(input int p);
    return (p < MINP) ? MINP : p;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mrun = 0; mt = 0; mlen = 0; mwake = 0;
    end else if (!mrun) begin
      if (en && !pd) begin
        if (mwake == WAKE - 1) begin
          mrun = 1; mt = 0; mwake = 0; mlen = 2 * eff(int'(period)) * HALF;
        end else mwake++;
      end else mwake = 0;
    end else if (mt == mlen - 1) begin
      if (en && !pd) begin mt = 0; mlen = 2 * eff(int'(period)) * HALF; end
      else begin mrun = 0; mwake = 0; end
    end else mt++;
  end

  // comparison and measurement
  bit prev_cs = 1;
  int last_fall = 0, prev_fall = 0, fall_cnt = 0, low_len = 0, vcount = 0;
  int last_exp = 0;
  always @(negedge clk) begin
    bit ecs, esc, ev;
    ecs = !(mrun && mt < 33 * HALF);
    esc = mrun && mt < 32 * HALF && ((mt / HALF) % 2 == 1);
    ev  = mrun && mt == 33 * HALF;
    chk(cs_n == ecs, "R2 cs_n", int'(cs_n), int'(ecs));
    chk(sclk == esc, "R3 sclk", int'(sclk), int'(esc));
    chk(valid == ev, "R5 valid", int'(valid), int'(ev));
    if (ev) begin
      if (exp_q.size() > 0) last_exp = exp_q.pop_front();
      chk(int'(sample) == last_exp, "R4 sample", int'(sample), last_exp);
    end else if (rst_n) begin
      chk(int'(sample) == last_exp, "R5 hold", int'(sample), last_exp);
    end
    if (valid) vcount++;
    if (prev_cs && !cs_n) begin prev_fall = last_fall; last_fall = cyc; fall_cnt++; end
    if (!prev_cs && cs_n) low_len = cyc - last_fall;
    prev_cs = cs_n;
  end

  task automatic wait_valids(input int n);
    int t = vcount + n;
    while (vcount < t) @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int rel, fc, vc;
    wait_cyc(4);
    chk(cs_n == 1 && sclk == 0 && valid == 0, "R1 idle pins", int'({cs_n, sclk, valid}), 4);
    chk(sample == 0, "R1 sample", int'(sample), 0);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && valid == 0 && sample == 0, "R1 after release",
        int'({cs_n, sclk, valid}), 4);

    en = 1; rel = cyc;
    wait (fall_cnt == 1); @(negedge clk);
    chk(last_fall - rel == WAKE, "R8 first start", last_fall - rel, WAKE);
    wait_valids(4);
    chk(last_fall - prev_fall == 2 * 25 * HALF, "R6 period 25", last_fall - prev_fall, 350);
    chk(low_len == 33 * HALF, "R2 cs low length", low_len, 231);

    period = 8'd5;
    wait_valids(3);
    chk(last_fall - prev_fall == 2 * MINP * HALF, "R6 clamp", last_fall - prev_fall, 280);
    period = 8'd30;
    wait_valids(3);
    chk(last_fall - prev_fall == 2 * 30 * HALF, "R6 period 30", last_fall - prev_fall, 420);

    fc = fall_cnt;
    wait (fall_cnt == fc + 1);
    wait_cyc(50);
    pd = 1; vc = vcount; fc = fall_cnt;
    wait_cyc(1200);
    chk(vcount == vc + 1, "R7 frame completes", vcount, vc + 1);
    chk(low_len == 33 * HALF, "R7 full frame under pd", low_len, 231);
    chk(fall_cnt == fc, "R7 no start in pd", fall_cnt, fc);
    chk(cs_n == 1 && sclk == 0, "R7 idle pins", int'({cs_n, sclk}), 2);

    pd = 0; rel = cyc; fc = fall_cnt;
    wait (fall_cnt == fc + 1); @(negedge clk);
    chk(last_fall - rel == WAKE, "R8 wake after pd", last_fall - rel, WAKE);
    wait_valids(2);

    wait_cyc(20);
    en = 0; fc = fall_cnt;
    wait_cyc(700);
    chk(fall_cnt == fc, "R7 no start when disabled", fall_cnt, fc);
    en = 1; wait_cyc(60);
    en = 0; wait_cyc(5);
    en = 1; rel = cyc;
    wait (fall_cnt == fc + 1); @(negedge clk);
    chk(last_fall - rel == WAKE, "R8 count restarts", last_fall - rel, WAKE);
    wait_valids(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule